// File: doc/BRIEF.md
# Core Module Control Register Block

This block is the control and status register file of a processor core module. It sits on a simple 32-bit register bus with byte addresses, where each register is one aligned word. It holds two oscillator setting registers that accept writes only while a 16-bit unlock key is held. A control register drives two outputs: a boot-remap signal and a miscellaneous LED. Writing its reset bit also sends a one-cycle reset request out to the system.

The block also holds two flag banks, a volatile one and a non-volatile one. Each bank has a write-one-to-set address and a write-one-to-clear address. A memory configuration word and an init word are freely writable. Three identification words are fixed. A read-only window returns the bytes of a memory-module descriptor, and one byte of that descriptor, like the size code in the memory configuration word, is derived from the fitted memory size parameter.

A read accepted on one clock edge returns its data, with a valid strobe, in the following cycle. Accesses to offsets the block does not implement, and writes to read-only offsets, return zero, change nothing and raise a one-cycle error flag.

Top module: `cmctl_top`

## Requirements
- R1: After reset the main oscillator word (byte 0x08) reads 0x01000048, the auxiliary oscillator word (0x1C) reads 0x0007FEFF, the init word (0x24) reads 0x00000112, the lock word (0x14) reads 0, the control word (0x0C) reads 0 and both flag banks read 0. The memory configuration word (0x20) reads 0x00011122 ORed with a size code: 0x10 for at least 256 MB, 0x0C for at least 128 MB, 0x08 for at least 64 MB, 0x04 for at least 32 MB, and 0 otherwise.
- R2: A write to the lock word keeps only bits 15:0 of the data. A read returns 0x0001A05F while the stored value equals the key 0xA05F, and the stored value otherwise.
- R3: Writes to the main and auxiliary oscillator words change them only while the lock word holds the key. Otherwise such a write is ignored and raises no error.
- R4: A write to the control word stores only bit 0 (LED) and bit 2 (remap). A read returns those two bits in place, with every other bit, including the reset bit 3, reading 0.
- R5: A control write with bit 3 set drives reset_req_o high for exactly the one cycle after the accepting edge. It does not reset any register of the block.
- R6: remap_o equals stored control bit 2, where 1 means the boot flash is unmapped from address zero. led_o equals stored control bit 0.
- R7: A write to 0x30 ORs the data into the flags and a write to 0x34 clears the flag bits written as 1; a read of 0x30 returns the flags. Addresses 0x38 and 0x3C do the same for the non-volatile flags, which are read at 0x38. The two banks are independent.
- R8: The identification word (0x00) reads 0x411A3001, the processor word (0x04) reads 0 and the status word (0x10) reads 0x00100000.
- R9: The memory configuration and init words store any written value with no lock.
- R10: A read of byte offset 0x100+4k, for k from 0 to 31, returns descriptor byte k in bits 7:0. Byte 31 is the density code: 64, 32, 16, 4 or 2 for the same size classes as R1. Offsets 0x180 to 0x1FF read 0. Neither raises an error.
- R11: The counter words (0x18, 0x28) and the voltage words (0x80 to 0x8C) read 0, ignore writes and raise no error.
- R12: Any other offset, a write to a read-only word (0x00, 0x04, 0x10, descriptor window) or a read of a clear-only address (0x34, 0x3C) returns 0, changes nothing and raises bus_err for one cycle.
- R13: bus_rvalid is high in the cycle after an accepted read and only then, with bus_rdata valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request, accepted on the rising edge |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe, one cycle after the read |
| bus_err | output | 1 | One-cycle flag for an unimplemented or illegal access |
| remap_o | output | 1 | 1 when the boot flash is unmapped from address zero |
| led_o | output | 1 | Miscellaneous LED drive |
| reset_req_o | output | 1 | One-cycle system reset request |

## Verification
The lock is tested in both states, with the oscillator writes arriving before the key, under the key and after the key is replaced by a different value. This separates a gate that tests the full 16-bit key from one that tests only some of its bits, and from no gate at all. The control word is written with all ones, all zeros and the remap bit alone, which tells the masking of unstored bits apart from the pulse, LED and remap paths, and shows whether the pulse lasts one cycle or more. Each flag bank gets overlapping set and clear patterns, and the other bank is read back afterwards, to expose OR-versus-overwrite mistakes and any cross-bank aliasing. The descriptor window is read at its first, middle and last entries and in its zero half, and error-class addresses are mixed with the silent zero words, so that decode mistakes show up as wrong data or a wrong error flag.

// File: rtl/cmctl_pkg.sv
package cmctl_pkg;

   localparam int DW = 32;

   // word indices inside the low 256-byte page
   localparam logic [5:0] WI_ID    = 6'd0;
   localparam logic [5:0] WI_PROC  = 6'd1;
   localparam logic [5:0] WI_OSC   = 6'd2;
   localparam logic [5:0] WI_CTRL  = 6'd3;
   localparam logic [5:0] WI_STAT  = 6'd4;
   localparam logic [5:0] WI_LOCK  = 6'd5;
   localparam logic [5:0] WI_CNT0  = 6'd6;
   localparam logic [5:0] WI_AUX   = 6'd7;
   localparam logic [5:0] WI_MCFG  = 6'd8;
   localparam logic [5:0] WI_INIT  = 6'd9;
   localparam logic [5:0] WI_CNT1  = 6'd10;
   localparam logic [5:0] WI_FSET  = 6'd12;
   localparam logic [5:0] WI_FCLR  = 6'd13;
   localparam logic [5:0] WI_NSET  = 6'd14;
   localparam logic [5:0] WI_NCLR  = 6'd15;

   // control word bit positions
   localparam int CB_LED   = 0;
   localparam int CB_REMAP = 2;
   localparam int CB_RESET = 3;

   typedef struct packed {
      logic id;
      logic proc;
      logic osc;
      logic ctrl;
      logic stat;
      logic lock;
      logic aux;
      logic mcfg;
      logic init;
      logic fset;
      logic fclr;
      logic nset;
      logic nclr;
      logic zero;
      logic win_lo;
      logic win_hi;
      logic bad;
   } hit_t;

   function automatic logic [7:0] density_code(input int mb);
      if (mb >= 256)     return 8'd64;
      else if (mb >= 128) return 8'd32;
      else if (mb >= 64)  return 8'd16;
      else if (mb >= 32)  return 8'd4;
      else                return 8'd2;
   endfunction

   function automatic logic [7:0] size_code(input int mb);
      if (mb >= 256)      return 8'h10;
      else if (mb >= 128) return 8'h0C;
      else if (mb >= 64)  return 8'h08;
      else if (mb >= 32)  return 8'h04;
      else                return 8'h00;
   endfunction

endpackage

// File: rtl/cmctl_decode.sv
module cmctl_decode
   import cmctl_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   output hit_t              hit
);
   localparam int PAGE_W = ADDR_W - 8;

   logic [PAGE_W-1:0] page;
   logic [5:0]        word;
   logic              in_base;
   logic              in_win;

   assign page    = addr[ADDR_W-1:8];
   assign word    = addr[7:2];
   assign in_base = (page == PAGE_W'(0));
   assign in_win  = (page == PAGE_W'(1));

   always_comb begin
      hit = '0;
      if (sel) begin
         if (in_win) begin
            hit.win_lo = ~addr[7] & ~wr;
            hit.win_hi =  addr[7] & ~wr;
            hit.bad    = wr;
         end else if (in_base) begin
            unique case (word)
               WI_ID:   begin hit.id   = ~wr; hit.bad = wr; end
               WI_PROC: begin hit.proc = ~wr; hit.bad = wr; end
               WI_STAT: begin hit.stat = ~wr; hit.bad = wr; end
               WI_OSC:  hit.osc  = 1'b1;
               WI_CTRL: hit.ctrl = 1'b1;
               WI_LOCK: hit.lock = 1'b1;
               WI_AUX:  hit.aux  = 1'b1;
               WI_MCFG: hit.mcfg = 1'b1;
               WI_INIT: hit.init = 1'b1;
               WI_FSET: hit.fset = 1'b1;
               WI_NSET: hit.nset = 1'b1;
               WI_FCLR: begin hit.fclr = wr; hit.bad = ~wr; end
               WI_NCLR: begin hit.nclr = wr; hit.bad = ~wr; end
               WI_CNT0, WI_CNT1,
               6'd32, 6'd33, 6'd34, 6'd35: hit.zero = 1'b1;
               default: hit.bad = 1'b1;
            endcase
         end else begin
            hit.bad = 1'b1;
         end
      end
   end
endmodule

// File: rtl/cmctl_keyed_osc.sv
module cmctl_keyed_osc #(
   parameter int          KEY_W   = 16,
   parameter logic [15:0] KEY     = 16'hA05F,
   parameter logic [31:0] OSC_RST = 32'h0100_0048,
   parameter logic [31:0] AUX_RST = 32'h0007_FEFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock_we,
   input  logic             osc_we,
   input  logic             aux_we,
   input  logic [31:0]      wdata,
   output logic [KEY_W-1:0] lock_q,
   output logic             key_held,
   output logic [31:0]      osc_q,
   output logic [31:0]      aux_q
);
   assign key_held = (lock_q == KEY[KEY_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= '0;
         osc_q  <= OSC_RST;
         aux_q  <= AUX_RST;
      end else begin
         if (lock_we)             lock_q <= wdata[KEY_W-1:0];
         if (osc_we && key_held)  osc_q  <= wdata;
         if (aux_we && key_held)  aux_q  <= wdata;
      end
   end
endmodule

// File: rtl/cmctl_setclr.sv
module cmctl_setclr #(
   parameter int         W   = 32,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= RST;
      else if (set_we) q <= q | wdata;
      else if (clr_we) q <= q & ~wdata;
   end
endmodule

// File: rtl/cmctl_descriptor.sv
module cmctl_descriptor
   import cmctl_pkg::*;
#(
   parameter int MEM_MB  = 128,
   parameter int ENTRIES = 32
) (
   input  logic [$clog2(ENTRIES)-1:0] idx,
   output logic [7:0]                 data
);
   localparam logic [7:0] DENS = density_code(MEM_MB);

   always_comb begin
      unique case (idx)
         5'd0:  data = 8'd128;
         5'd1:  data = 8'd8;
         5'd2:  data = 8'd4;
         5'd3:  data = 8'd11;
         5'd4:  data = 8'd9;
         5'd5:  data = 8'd1;
         5'd6:  data = 8'd64;
         5'd8:  data = 8'd2;
         5'd9:  data = 8'hA0;
         5'd10: data = 8'hA0;
         5'd13: data = 8'd8;
         5'd15: data = 8'd1;
         5'd16: data = 8'h0E;
         5'd17: data = 8'd4;
         5'd18: data = 8'h1C;
         5'd19: data = 8'd1;
         5'd20: data = 8'd2;
         5'd21: data = 8'h20;
         5'd22: data = 8'hC0;
         5'd27: data = 8'h30;
         5'd28: data = 8'h28;
         5'd29: data = 8'h30;
         5'd30: data = 8'h28;
         5'd31: data = DENS;
         default: data = 8'd0;
      endcase
   end
endmodule

// File: rtl/cmctl_top.sv
module cmctl_top
   import cmctl_pkg::*;
#(
   parameter int          ADDR_W     = 10,
   parameter int          MEM_MB     = 128,
   parameter int          KEY_W      = 16,
   parameter logic [15:0] LOCK_KEY   = 16'hA05F,
   parameter logic [31:0] ID_WORD    = 32'h411A_3001,
   parameter logic [31:0] STAT_WORD  = 32'h0010_0000,
   parameter logic [31:0] OSC_RST    = 32'h0100_0048,
   parameter logic [31:0] AUX_RST    = 32'h0007_FEFF,
   parameter logic [31:0] INIT_RST   = 32'h0000_0112,
   parameter logic [31:0] MCFG_BASE  = 32'h0001_1122,
   parameter int          DESC_N     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_rvalid,
   output logic              bus_err,
   output logic              remap_o,
   output logic              led_o,
   output logic              reset_req_o
);
   localparam int          NBANK    = 2;
   localparam int          DIDX_W   = $clog2(DESC_N);
   localparam logic [31:0] MCFG_RST = MCFG_BASE | {24'd0, size_code(MEM_MB)};
   localparam logic [31:0] KEY_RD   = {15'd0, 1'b1, LOCK_KEY};

   if (ADDR_W < 10) begin : g_addr_chk
      $error("cmctl_top: ADDR_W must be at least 10");
   end
   if (KEY_W != 16) begin : g_key_chk
      $error("cmctl_top: KEY_W must be 16");
   end
   if (DESC_N != 32) begin : g_desc_chk
      $error("cmctl_top: descriptor window holds 32 entries");
   end

   hit_t hit;
   logic wr_acc;

   cmctl_decode #(.ADDR_W(ADDR_W)) u_dec (
      .sel  (bus_sel),
      .wr   (bus_wr),
      .addr (bus_addr),
      .hit  (hit)
   );

   assign wr_acc = bus_sel & bus_wr & ~hit.bad;

   // keyed oscillator settings
   logic [KEY_W-1:0] lock_q;
   logic             key_held;
   logic [31:0]      osc_q;
   logic [31:0]      aux_q;

   cmctl_keyed_osc #(
      .KEY_W   (KEY_W),
      .KEY     (LOCK_KEY),
      .OSC_RST (OSC_RST),
      .AUX_RST (AUX_RST)
   ) u_osc (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock_we  (wr_acc & hit.lock),
      .osc_we   (wr_acc & hit.osc),
      .aux_we   (wr_acc & hit.aux),
      .wdata    (bus_wdata),
      .lock_q   (lock_q),
      .key_held (key_held),
      .osc_q    (osc_q),
      .aux_q    (aux_q)
   );

   // flag banks: 0 = volatile, 1 = non-volatile
   logic [NBANK-1:0] bank_set;
   logic [NBANK-1:0] bank_clr;
   logic [31:0]      bank_q [NBANK];

   assign bank_set = {wr_acc & hit.nset, wr_acc & hit.fset};
   assign bank_clr = {wr_acc & hit.nclr, wr_acc & hit.fclr};

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      cmctl_setclr #(.W(32), .RST(32'd0)) u_flags (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_we (bank_set[b]),
         .clr_we (bank_clr[b]),
         .wdata  (bus_wdata),
         .q      (bank_q[b])
      );
   end

   // free words
   logic [31:0] mcfg_q;
   logic [31:0] init_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcfg_q <= MCFG_RST;
         init_q <= INIT_RST;
      end else begin
         if (wr_acc && hit.mcfg) mcfg_q <= bus_wdata;
         if (wr_acc && hit.init) init_q <= bus_wdata;
      end
   end

   // control word and reset pulse
   logic led_q;
   logic remap_q;
   logic rst_pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         led_q       <= 1'b0;
         remap_q     <= 1'b0;
         rst_pulse_q <= 1'b0;
      end else begin
         rst_pulse_q <= wr_acc & hit.ctrl & bus_wdata[CB_RESET];
         if (wr_acc && hit.ctrl) begin
            led_q   <= bus_wdata[CB_LED];
            remap_q <= bus_wdata[CB_REMAP];
         end
      end
   end

   assign led_o       = led_q;
   assign remap_o     = remap_q;
   assign reset_req_o = rst_pulse_q;

   // descriptor window
   logic [7:0] desc_byte;

   cmctl_descriptor #(.MEM_MB(MEM_MB), .ENTRIES(DESC_N)) u_desc (
      .idx  (bus_addr[DIDX_W+1:2]),
      .data (desc_byte)
   );

   // read mux
   logic [31:0] ctrl_rd;
   logic [31:0] lock_rd;
   logic [31:0] rd_mux;

   always_comb begin
      ctrl_rd           = '0;
      ctrl_rd[CB_LED]   = led_q;
      ctrl_rd[CB_REMAP] = remap_q;
      lock_rd           = key_held ? KEY_RD : {{(32-KEY_W){1'b0}}, lock_q};
   end

   always_comb begin
      rd_mux = '0;
      if      (hit.id)     rd_mux = ID_WORD;
      else if (hit.stat)   rd_mux = STAT_WORD;
      else if (hit.osc)    rd_mux = osc_q;
      else if (hit.aux)    rd_mux = aux_q;
      else if (hit.ctrl)   rd_mux = ctrl_rd;
      else if (hit.lock)   rd_mux = lock_rd;
      else if (hit.mcfg)   rd_mux = mcfg_q;
      else if (hit.init)   rd_mux = init_q;
      else if (hit.fset)   rd_mux = bank_q[0];
      else if (hit.nset)   rd_mux = bank_q[1];
      else if (hit.win_lo) rd_mux = {24'd0, desc_byte};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
         bus_err    <= 1'b0;
      end else begin
         bus_rvalid <= bus_sel & ~bus_wr;
         bus_rdata  <= (bus_sel && !bus_wr) ? rd_mux : 32'd0;
         bus_err    <= bus_sel & hit.bad;
      end
   end
endmodule

// File: rtl/cmctl_chk.sv
module cmctl_chk #(
   parameter int ADDR_W = 10,
   parameter int KEY_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              bus_rvalid,
   input logic              bus_err,
   input logic              remap_o,
   input logic              led_o,
   input logic              reset_req_o,
   input logic              key_held,
   input logic [KEY_W-1:0]  lock_q,
   input logic [31:0]       osc_q,
   input logic [31:0]       aux_q
);
   logic wr_at;
   logic w_ctrl, w_lock, w_osc, w_aux;

   assign wr_at  = bus_sel & bus_wr;
   assign w_ctrl = wr_at & (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(3));
   assign w_lock = wr_at & (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(5));
   assign w_osc  = wr_at & (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(2));
   assign w_aux  = wr_at & (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(7));

   // R2
   lock_low16_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w_lock |=> lock_q == $past(bus_wdata[KEY_W-1:0]));

   // R3
   osc_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_osc && !key_held) |=> $stable(osc_q));

   // R3
   aux_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_aux && !key_held) |=> $stable(aux_q));

   // R5
   rst_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req_o |-> $past(w_ctrl && bus_wdata[3]));

   // R6
   remap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !w_ctrl |=> $stable(remap_o));

   // R6
   led_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w_ctrl |=> led_o == $past(bus_wdata[0]));

   // R12
   err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past(bus_sel));

   // R13
   rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> $past(bus_sel && !bus_wr));
endmodule

bind cmctl_top cmctl_chk #(.ADDR_W(ADDR_W), .KEY_W(KEY_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_sel     (bus_sel),
   .bus_wr      (bus_wr),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .bus_rvalid  (bus_rvalid),
   .bus_err     (bus_err),
   .remap_o     (remap_o),
   .led_o       (led_o),
   .reset_req_o (reset_req_o),
   .key_held    (key_held),
   .lock_q      (lock_q),
   .osc_q       (osc_q),
   .aux_q       (aux_q)
);

// File: tb/tb_cmctl_top.sv
`timescale 1ns/1ps
module tb_cmctl_top;
   localparam int ADDR_W = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_sel = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              bus_rvalid;
   logic              bus_err;
   logic              remap_o;
   logic              led_o;
   logic              reset_req_o;

   int n_chk = 0;
   int n_bad = 0;
   logic last_err;
   logic last_rst;
   logic last_rv;

   always #10 clk = ~clk;

   cmctl_top #(.ADDR_W(ADDR_W), .MEM_MB(128)) dut (
      .clk (clk), .rst_n (rst_n),
      .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
      .bus_rvalid (bus_rvalid), .bus_err (bus_err),
      .remap_o (remap_o), .led_o (led_o), .reset_req_o (reset_req_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      last_err = bus_err; last_rst = reset_req_o; last_rv = bus_rvalid;
   endtask

   task automatic rd(input string tag, input logic [ADDR_W-1:0] a,
                     input logic [31:0] exp, input logic exp_err);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      check({tag, " data"}, bus_rdata, exp);
      check({tag, " err"}, {31'd0, bus_err}, {31'd0, exp_err});
      check({tag, " rvalid"}, {31'd0, bus_rvalid}, 32'd1);
   endtask

   task automatic t_reset_state;
      check("R6 remap after reset", {31'd0, remap_o}, 32'd0);
      check("R6 led after reset", {31'd0, led_o}, 32'd0);
      rd("R1 osc", 10'h008, 32'h0100_0048, 1'b0);
      rd("R1 aux", 10'h01C, 32'h0007_FEFF, 1'b0);
      rd("R1 init", 10'h024, 32'h0000_0112, 1'b0);
      rd("R1 mcfg", 10'h020, 32'h0001_112E, 1'b0);
      rd("R1 lock", 10'h014, 32'd0, 1'b0);
      rd("R1 ctrl", 10'h00C, 32'd0, 1'b0);
      rd("R1 flags", 10'h030, 32'd0, 1'b0);
      rd("R1 nvflags", 10'h038, 32'd0, 1'b0);
   endtask

   task automatic t_ident;
      rd("R8 id", 10'h000, 32'h411A_3001, 1'b0);
      rd("R8 proc", 10'h004, 32'd0, 1'b0);
      rd("R8 stat", 10'h010, 32'h0010_0000, 1'b0);
   endtask

   task automatic t_lock;
      wr(10'h008, 32'h1111_1111);
      check("R3 locked osc write no err", {31'd0, last_err}, 32'd0);
      rd("R3 osc unchanged", 10'h008, 32'h0100_0048, 1'b0);
      wr(10'h014, 32'hA05E);
      wr(10'h01C, 32'h5555_5555);
      rd("R3 near key aux", 10'h01C, 32'h0007_FEFF, 1'b0);
      rd("R2 near key read", 10'h014, 32'h0000_A05E, 1'b0);
      wr(10'h014, 32'h1234_A05F);
      rd("R2 key read", 10'h014, 32'h0001_A05F, 1'b0);
      wr(10'h008, 32'h0000_0022);
      rd("R3 unlocked osc", 10'h008, 32'h0000_0022, 1'b0);
      wr(10'h01C, 32'h0000_0033);
      rd("R3 unlocked aux", 10'h01C, 32'h0000_0033, 1'b0);
      wr(10'h014, 32'hBEEF_0001);
      rd("R2 low16 kept", 10'h014, 32'h0000_0001, 1'b0);
      wr(10'h01C, 32'h0000_0044);
      rd("R3 relocked aux", 10'h01C, 32'h0000_0033, 1'b0);
   endtask

   task automatic t_ctrl;
      wr(10'h00C, 32'hFFFF_FFFF);
      check("R5 pulse on write", {31'd0, last_rst}, 32'd1);
      @(negedge clk);
      check("R5 pulse one cycle", {31'd0, reset_req_o}, 32'd0);
      check("R6 remap set", {31'd0, remap_o}, 32'd1);
      check("R6 led set", {31'd0, led_o}, 32'd1);
      rd("R4 ctrl readback", 10'h00C, 32'h0000_0005, 1'b0);
      rd("R5 osc survives", 10'h008, 32'h0000_0022, 1'b0);
      wr(10'h00C, 32'h0000_0000);
      check("R5 no pulse", {31'd0, last_rst}, 32'd0);
      check("R6 remap clear", {31'd0, remap_o}, 32'd0);
      check("R6 led clear", {31'd0, led_o}, 32'd0);
      wr(10'h00C, 32'h0000_0004);
      check("R6 remap only", {30'd0, remap_o, led_o}, 32'd2);
      rd("R4 remap only read", 10'h00C, 32'h0000_0004, 1'b0);
   endtask

   task automatic t_flags;
      wr(10'h030, 32'h0000_00F0);
      wr(10'h030, 32'h0000_000F);
      rd("R7 flags set OR", 10'h030, 32'h0000_00FF, 1'b0);
      wr(10'h034, 32'h0000_003C);
      rd("R7 flags clear", 10'h030, 32'h0000_00C3, 1'b0);
      wr(10'h038, 32'hA500_0000);
      rd("R7 nv set", 10'h038, 32'hA500_0000, 1'b0);
      rd("R7 bank independent", 10'h030, 32'h0000_00C3, 1'b0);
      wr(10'h03C, 32'h0500_0000);
      rd("R7 nv clear", 10'h038, 32'hA000_0000, 1'b0);
   endtask

   task automatic t_free;
      wr(10'h020, 32'h0000_DEAD);
      rd("R9 mcfg", 10'h020, 32'h0000_DEAD, 1'b0);
      wr(10'h024, 32'h0000_0007);
      rd("R9 init", 10'h024, 32'h0000_0007, 1'b0);
   endtask

   task automatic t_window;
      rd("R10 entry0", 10'h100, 32'h0000_0080, 1'b0);
      rd("R10 entry1", 10'h104, 32'h0000_0008, 1'b0);
      rd("R10 entry9", 10'h124, 32'h0000_00A0, 1'b0);
      rd("R10 entry31 density", 10'h17C, 32'h0000_0020, 1'b0);
      rd("R10 upper half 0x180", 10'h180, 32'd0, 1'b0);
      rd("R10 upper half 0x1FC", 10'h1FC, 32'd0, 1'b0);
   endtask

   task automatic t_zero_words;
      rd("R11 counter0", 10'h018, 32'd0, 1'b0);
      rd("R11 counter1", 10'h028, 32'd0, 1'b0);
      rd("R11 voltage", 10'h080, 32'd0, 1'b0);
      wr(10'h08C, 32'hFFFF_FFFF);
      check("R11 voltage write no err", {31'd0, last_err}, 32'd0);
      rd("R11 voltage after write", 10'h08C, 32'd0, 1'b0);
   endtask

   task automatic t_unimpl;
      rd("R12 word11", 10'h02C, 32'd0, 1'b1);
      @(negedge clk);
      check("R12 err one cycle", {31'd0, bus_err}, 32'd0);
      rd("R12 clr read", 10'h034, 32'd0, 1'b1);
      rd("R12 above window", 10'h200, 32'd0, 1'b1);
      wr(10'h040, 32'hFFFF_FFFF);
      check("R12 word16 write err", {31'd0, last_err}, 32'd1);
      check("R13 no rvalid on write", {31'd0, last_rv}, 32'd0);
      wr(10'h000, 32'h0);
      check("R12 id write err", {31'd0, last_err}, 32'd1);
      rd("R12 id unchanged", 10'h000, 32'h411A_3001, 1'b0);
      wr(10'h100, 32'h0);
      check("R12 window write err", {31'd0, last_err}, 32'd1);
      rd("R12 window unchanged", 10'h100, 32'h0000_0080, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_ident();
      t_lock();
      t_ctrl();
      t_flags();
      t_free();
      t_window();
      t_zero_words();
      t_unimpl();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule